// File: doc/BRIEF.md
# Tag-Extended L1 Data Array With Tag Access

This block is the data-storage slice of a first-level cache in which each 64-bit double word of a line carries a small metadata tag beside its data. A line holds eight double words. With the default 4-bit tag, the stored line grows from 512 to 544 bits. The array is a direct-mapped test array. Each set keeps a valid bit and an address tag, and each access reports whether it hit.

One request port carries five operations: a data load, a data store, a tag load, a tag store and a line fill. Every operation forms its effective address as a 64-bit base plus a sign-extended 12-bit immediate. The two tag operations read or write only the tag field of the addressed double word. They flag a misalignment exception in the request cycle when the effective address is not a multiple of 8, and in that case nothing in the array is touched. Data stores leave tags alone. A fill writes a whole line together with its eight tags. Loads of either kind answer one cycle later with a valid pulse.

Top module: `tagged_l1_slice`

## Requirements
- R1: The effective address is `req_base` plus `req_imm` sign-extended from 12 to 64 bits, modulo 2^64. The double word is selected by address bits [5:3], the set by bits [8:6] (default 8 sets), and the address tag is bits [63:9].
- R2: A tag load (op 3) or tag store (op 4) whose effective address has any of bits [2:0] set raises `excp_misalign` in the same cycle as the request. It then produces no response and changes no stored data, tag or valid bit. Data ops (1, 2) and fills (5) never raise it.
- R3: A tag load (op 3) that hits returns the addressed tag zero-extended to 64 bits on `rsp_data`, with `rsp_valid` high in the cycle after the request.
- R4: A tag store (op 4) that hits writes bits [TAG_W-1:0] of `req_wdata` into the tag of the addressed double word only. Data and the other tags stay unchanged.
- R5: A data store (op 2) that hits replaces the 64-bit data of the addressed double word and leaves its tag unchanged.
- R6: A fill (op 5) stores `fill_data[64k+63:64k]` as double word k and `fill_tags[TAG_W*k+TAG_W-1:TAG_W*k]` as its tag, for all eight k. It also sets the set valid and records the address tag.
- R7: An access hits only when the set is valid and its recorded address tag equals the request's. A missing load answers with `rsp_hit` low and `rsp_data` zero. A missing store of either kind changes nothing.
- R8: A data load (op 1) answers in the cycle after the request with `rsp_valid` high, `rsp_hit`, and the 64-bit data on `rsp_data`. Op 0 is idle and gives no response.
- R9: After reset every set is invalid, and `rsp_valid` and `excp_misalign` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 idle, 1 data load, 2 data store, 3 tag load, 4 tag store, 5 fill |
| req_base | input | 64 | Base register value |
| req_imm | input | 12 | Signed address offset |
| req_wdata | input | 64 | Store data, or tag source register for a tag store |
| fill_data | input | 512 | Line data for a fill, double word k at bits 64k upward |
| fill_tags | input | 32 | Line tags for a fill, tag k at bits TAG_W*k upward |
| excp_misalign | output | 1 | Misaligned tag operation, same cycle as the request |
| rsp_valid | output | 1 | Load response present |
| rsp_hit | output | 1 | Response came from a valid matching line |
| rsp_data | output | 64 | Loaded data or zero-extended tag |

## Verification
A corrupted tag or data field stays hidden until something reads that double word. The bench therefore follows every store, tag store and fill with tag and data loads on the target and on its neighbours, so a wrong write shows on `rsp_data` one cycle after the read request. A wrong valid bit or recorded address tag shows as a wrong `rsp_hit` on the next load to that set. An alignment error shows on `excp_misalign` in the request cycle itself. A misaligned tag store that wrongly wrote the array is caught by the aligned tag load that follows it.

// File: rtl/tagl1_pkg.sv
package tagl1_pkg;

    localparam int unsigned WORD_W = 64;
    localparam int unsigned IMM_W  = 12;
    localparam int unsigned OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE = 3'd0,
        OP_LDD  = 3'd1,
        OP_STD  = 3'd2,
        OP_LDT  = 3'd3,
        OP_STT  = 3'd4,
        OP_FIL  = 3'd5
    } op_e;

endpackage

// File: rtl/tagl1_agen.sv
module tagl1_agen
    import tagl1_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned SETS   = 8,
    parameter int unsigned DWS    = 8
) (
    input  logic                  req_valid_i,
    input  op_e                   op_i,
    input  logic [ADDR_W-1:0]     base_i,
    input  logic [IMM_W-1:0]      imm_i,
    output logic [$clog2(SETS)-1:0] idx_o,
    output logic [$clog2(DWS)-1:0]  dsel_o,
    output logic [ADDR_W-$clog2(SETS)-$clog2(DWS)-$clog2(WORD_W/8)-1:0] ltag_o,
    output logic                  misalign_o,
    output logic                  rd_data_o,
    output logic                  rd_tag_o,
    output logic                  we_data_o,
    output logic                  we_tag_o,
    output logic                  fill_o
);

    localparam int unsigned BYTE_W = $clog2(WORD_W/8);
    localparam int unsigned DSEL_W = $clog2(DWS);
    localparam int unsigned IDX_W  = $clog2(SETS);
    localparam int unsigned OFF_W  = BYTE_W + DSEL_W;
    localparam int unsigned LTAG_W = ADDR_W - OFF_W - IDX_W;

    logic [ADDR_W-1:0] ea;
    logic              is_tag_op;
    logic              go;

    always_comb begin
        ea         = base_i + {{(ADDR_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
        is_tag_op  = (op_i == OP_LDT) || (op_i == OP_STT);
        misalign_o = req_valid_i && is_tag_op && (|ea[BYTE_W-1:0]);
        go         = req_valid_i && !misalign_o;

        dsel_o = ea[BYTE_W +: DSEL_W];
        idx_o  = ea[OFF_W +: IDX_W];
        ltag_o = ea[ADDR_W-1 -: LTAG_W];

        rd_data_o = go && (op_i == OP_LDD);
        rd_tag_o  = go && (op_i == OP_LDT);
        we_data_o = go && (op_i == OP_STD);
        we_tag_o  = go && (op_i == OP_STT);
        fill_o    = go && (op_i == OP_FIL);
    end

endmodule

// File: rtl/tagl1_array.sv
module tagl1_array
    import tagl1_pkg::*;
#(
    parameter int unsigned SETS   = 8,
    parameter int unsigned DWS    = 8,
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned LTAG_W = 55
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [$clog2(SETS)-1:0]    idx_i,
    input  logic [$clog2(DWS)-1:0]     dsel_i,
    input  logic [LTAG_W-1:0]          ltag_i,
    input  logic                       we_data_i,
    input  logic                       we_tag_i,
    input  logic                       fill_i,
    input  logic [WORD_W-1:0]          wdata_i,
    input  logic [TAG_W-1:0]           wtag_i,
    input  logic [DWS*WORD_W-1:0]      fill_data_i,
    input  logic [DWS*TAG_W-1:0]       fill_tags_i,
    output logic                       hit_o,
    output logic [WORD_W-1:0]          rdata_o,
    output logic [TAG_W-1:0]           rtag_o
);

    localparam int unsigned LINE_BITS = DWS * (WORD_W + TAG_W);

    typedef struct packed {
        logic [SETS-1:0]                         vld;
        logic [SETS-1:0][LTAG_W-1:0]             atag;
        logic [SETS-1:0][DWS-1:0][WORD_W-1:0]    data;
        logic [SETS-1:0][DWS-1:0][TAG_W-1:0]     tags;
    } arr_t;

    arr_t arr_d, arr_q;
    logic [DWS-1:0][WORD_W-1:0] fill_words;
    logic [DWS-1:0][TAG_W-1:0]  fill_marks;

    for (genvar k = 0; k < DWS; k++) begin : g_fill_split
        assign fill_words[k] = fill_data_i[k*WORD_W +: WORD_W];
        assign fill_marks[k] = fill_tags_i[k*TAG_W +: TAG_W];
    end

    always_comb begin
        arr_d   = arr_q;
        hit_o   = arr_q.vld[idx_i] && (arr_q.atag[idx_i] == ltag_i);
        rdata_o = arr_q.data[idx_i][dsel_i];
        rtag_o  = arr_q.tags[idx_i][dsel_i];

        if (fill_i) begin
            arr_d.vld[idx_i]  = 1'b1;
            arr_d.atag[idx_i] = ltag_i;
            arr_d.data[idx_i] = fill_words;
            arr_d.tags[idx_i] = fill_marks;
        end
        if (we_data_i && hit_o) begin
            arr_d.data[idx_i][dsel_i] = wdata_i;
        end
        if (we_tag_i && hit_o) begin
            arr_d.tags[idx_i][dsel_i] = wtag_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            arr_q <= '0;
        end else begin
            arr_q <= arr_d;
        end
    end

    initial begin
        AST_LINE_WIDTH: assert ($bits(arr_q.data[0]) + $bits(arr_q.tags[0]) == LINE_BITS); // R6
    end

    AST_FILL_MARKS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fill_i |=> (arr_q.vld[$past(idx_i)] && arr_q.atag[$past(idx_i)] == $past(ltag_i))); // R6

    AST_TAGWR_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_tag_i |=> arr_q.data[$past(idx_i)][$past(dsel_i)] == $past(arr_q.data[idx_i][dsel_i])); // R4

    AST_DATAWR_KEEPS_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_data_i |=> arr_q.tags[$past(idx_i)][$past(dsel_i)] == $past(arr_q.tags[idx_i][dsel_i])); // R5

    AST_MISS_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((we_data_i || we_tag_i) && !hit_o) |=> $stable(arr_q)); // R7

endmodule

// File: rtl/tagl1_resp.sv
module tagl1_resp
    import tagl1_pkg::*;
#(
    parameter int unsigned TAG_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_data_i,
    input  logic              rd_tag_i,
    input  logic              hit_i,
    input  logic [WORD_W-1:0] rdata_i,
    input  logic [TAG_W-1:0]  rtag_i,
    output logic              rsp_valid_o,
    output logic              rsp_hit_o,
    output logic [WORD_W-1:0] rsp_data_o
);

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              is_tag;
        logic [WORD_W-1:0] data;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d        = '0;
        rsp_d.valid  = rd_data_i || rd_tag_i;
        rsp_d.is_tag = rd_tag_i;
        rsp_d.hit    = rsp_d.valid && hit_i;
        if (rsp_d.hit) begin
            rsp_d.data = rd_tag_i ? {{(WORD_W-TAG_W){1'b0}}, rtag_i} : rdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid_o = rsp_q.valid;
    assign rsp_hit_o   = rsp_q.hit;
    assign rsp_data_o  = rsp_q.data;

    AST_MISS_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_q.valid && !rsp_q.hit) |-> rsp_q.data == '0); // R7

    AST_TAG_ZERO_EXTENDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_q.valid && rsp_q.is_tag) |-> rsp_q.data[WORD_W-1:TAG_W] == '0); // R3

endmodule

// File: rtl/tagged_l1_slice.sv
module tagged_l1_slice
    import tagl1_pkg::*;
#(
    parameter int unsigned SETS  = 8,
    parameter int unsigned DWS   = 8,
    parameter int unsigned TAG_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [2:0]              req_op,
    input  logic [63:0]             req_base,
    input  logic [11:0]             req_imm,
    input  logic [63:0]             req_wdata,
    input  logic [DWS*64-1:0]       fill_data,
    input  logic [DWS*TAG_W-1:0]    fill_tags,
    output logic                    excp_misalign,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic [63:0]             rsp_data
);

    localparam int unsigned ADDR_W = 64;
    localparam int unsigned IDX_W  = $clog2(SETS);
    localparam int unsigned DSEL_W = $clog2(DWS);
    localparam int unsigned LTAG_W = ADDR_W - IDX_W - DSEL_W - $clog2(WORD_W/8);

    logic [IDX_W-1:0]  idx;
    logic [DSEL_W-1:0] dsel;
    logic [LTAG_W-1:0] ltag;
    logic              rd_data, rd_tag, we_data, we_tag, fill;
    logic              hit;
    logic [WORD_W-1:0] rdata;
    logic [TAG_W-1:0]  rtag;

    tagl1_agen #(
        .ADDR_W (ADDR_W),
        .SETS   (SETS),
        .DWS    (DWS)
    ) u_agen (
        .req_valid_i (req_valid),
        .op_i        (op_e'(req_op)),
        .base_i      (req_base),
        .imm_i       (req_imm),
        .idx_o       (idx),
        .dsel_o      (dsel),
        .ltag_o      (ltag),
        .misalign_o  (excp_misalign),
        .rd_data_o   (rd_data),
        .rd_tag_o    (rd_tag),
        .we_data_o   (we_data),
        .we_tag_o    (we_tag),
        .fill_o      (fill)
    );

    tagl1_array #(
        .SETS   (SETS),
        .DWS    (DWS),
        .TAG_W  (TAG_W),
        .LTAG_W (LTAG_W)
    ) u_array (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .idx_i       (idx),
        .dsel_i      (dsel),
        .ltag_i      (ltag),
        .we_data_i   (we_data),
        .we_tag_i    (we_tag),
        .fill_i      (fill),
        .wdata_i     (req_wdata),
        .wtag_i      (req_wdata[TAG_W-1:0]),
        .fill_data_i (fill_data),
        .fill_tags_i (fill_tags),
        .hit_o       (hit),
        .rdata_o     (rdata),
        .rtag_o      (rtag)
    );

    tagl1_resp #(
        .TAG_W (TAG_W)
    ) u_resp (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .rd_data_i   (rd_data),
        .rd_tag_i    (rd_tag),
        .hit_i       (hit),
        .rdata_i     (rdata),
        .rtag_i      (rtag),
        .rsp_valid_o (rsp_valid),
        .rsp_hit_o   (rsp_hit),
        .rsp_data_o  (rsp_data)
    );

    AST_MISALIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        excp_misalign |=> !rsp_valid); // R2

    AST_MISALIGN_TAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        excp_misalign |-> (req_valid && (req_op == 3'd3 || req_op == 3'd4))); // R2

    AST_RSP_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && (req_op == 3'd1 || req_op == 3'd3))); // R8

endmodule

// File: tb/sim_tagged_l1_slice.sv
module sim_tagged_l1_slice;

    localparam int CLK_PERIOD = 10;
    localparam int TW  = 4;
    localparam int NDW = 8;
    localparam int NST = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic [2:0]        req_op;
    logic [63:0]       req_base;
    logic [11:0]       req_imm;
    logic [63:0]       req_wdata;
    logic [NDW*64-1:0] fill_data;
    logic [NDW*TW-1:0] fill_tags;
    logic              excp_misalign;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [63:0]       rsp_data;

    tagged_l1_slice u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .req_base      (req_base),
        .req_imm       (req_imm),
        .req_wdata     (req_wdata),
        .fill_data     (fill_data),
        .fill_tags     (fill_tags),
        .excp_misalign (excp_misalign),
        .rsp_valid     (rsp_valid),
        .rsp_hit       (rsp_hit),
        .rsp_data      (rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [63:0] m_data [NST][NDW];
    logic [TW-1:0] m_tag [NST][NDW];
    logic        m_vld  [NST];
    logic [54:0] m_lt   [NST];

    logic [64:0] exp_q [$];
    string       exp_rq [$];

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [54:0] lt, input int set, input int dw);
        return {lt, 9'd0} | (64'(set) << 6) | (64'(dw) << 3);
    endfunction

    // Monitor: pops the oldest expected response when the design answers
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected response", rsp_data, 64'd0);
            end else begin
                logic [64:0] e;
                string r;
                e = exp_q.pop_front();
                r = exp_rq.pop_front();
                check(rsp_hit == e[64], r, "rsp_hit", 64'(rsp_hit), 64'(e[64]));
                check(rsp_data == e[63:0], r, "rsp_data", rsp_data, e[63:0]);
            end
        end
    end

    // Driver: applies one request and records its expected outcome
    task automatic issue(input logic [2:0] op, input logic [63:0] base, input logic [11:0] imm,
                         input logic [63:0] wd, input string rq);
        logic [63:0] ea;
        int idx, d;
        logic [54:0] lt;
        bit mis, hit;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_base  = base;
        req_imm   = imm;
        req_wdata = wd;
        ea  = base + {{52{imm[11]}}, imm};
        idx = int'(ea[8:6]);
        d   = int'(ea[5:3]);
        lt  = ea[63:9];
        mis = (op == 3'd3 || op == 3'd4) && (ea[2:0] != 3'd0);
        hit = m_vld[idx] && (m_lt[idx] == lt);
        #1;
        check(excp_misalign == mis, mis ? "R2" : rq, "misalign flag",
              64'(excp_misalign), 64'(mis));
        if (!mis) begin
            case (op)
                3'd1: begin
                    exp_q.push_back({hit, hit ? m_data[idx][d] : 64'd0});
                    exp_rq.push_back(rq);
                end
                3'd2: if (hit) m_data[idx][d] = wd;
                3'd3: begin
                    exp_q.push_back({hit, hit ? {60'd0, m_tag[idx][d]} : 64'd0});
                    exp_rq.push_back(rq);
                end
                3'd4: if (hit) m_tag[idx][d] = wd[TW-1:0];
                3'd5: begin
                    m_vld[idx] = 1'b1;
                    m_lt[idx]  = lt;
                    for (int k = 0; k < NDW; k++) begin
                        m_data[idx][k] = fill_data[k*64 +: 64];
                        m_tag[idx][k]  = fill_tags[k*TW +: TW];
                    end
                end
                default: ;
            endcase
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_op    = 3'd0;
        end
    endtask

    task automatic set_fill(input int seed);
        for (int k = 0; k < NDW; k++) begin
            fill_data[k*64 +: 64] = {32'hC0DE_0000 + 32'(seed), 32'h1111_0000 + 32'(k * 7)};
            fill_tags[k*TW +: TW] = TW'(seed + k + 1);
        end
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired, pending=%0d", exp_q.size());
        report();
    end

    initial begin
        logic [54:0] la, lb;
        la = 55'h1234;
        lb = 55'h0ABC;
        for (int s = 0; s < NST; s++) begin
            m_vld[s] = 1'b0;
            m_lt[s]  = '0;
            for (int k = 0; k < NDW; k++) begin
                m_data[s][k] = '0;
                m_tag[s][k]  = '0;
            end
        end
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_op = '0;
        req_base = '0;
        req_imm = '0;
        req_wdata = '0;
        fill_data = '0;
        fill_tags = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: reset state
        check(rsp_valid == 1'b0, "R9", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check(excp_misalign == 1'b0, "R9", "excp after reset", 64'(excp_misalign), 64'd0);

        // R9 / R7: every set starts invalid, loads miss with zero data
        issue(3'd1, mk(la, 2, 0), 12'd0, '0, "R9");
        issue(3'd3, mk(la, 5, 3), 12'd0, '0, "R7");
        idle(2);

        // R6: fill set 2 then read all tags and data back
        set_fill(3);
        issue(3'd5, mk(la, 2, 0), 12'd0, '0, "R6");
        for (int k = 0; k < NDW; k++) begin
            issue(3'd3, mk(la, 2, k), 12'd0, '0, "R6");
            issue(3'd1, mk(la, 2, k), 12'd0, '0, "R8");
        end

        // R1: negative offset reaches double word 5
        issue(3'd4, mk(la, 2, 5) + 64'h20, 12'hFE0, 64'hFFFF_FFFF_FFFF_FFA5, "R1");
        issue(3'd3, mk(la, 2, 5), 12'd0, '0, "R4");
        issue(3'd1, mk(la, 2, 5), 12'd0, '0, "R4");
        issue(3'd3, mk(la, 2, 4), 12'd0, '0, "R4");
        issue(3'd3, mk(la, 2, 6), 12'd0, '0, "R4");

        // R1: positive offset of 2040 and odd base with -1 offset
        issue(3'd3, mk(la, 2, 7) - 64'd2040, 12'd2040, '0, "R1");
        issue(3'd4, mk(la, 2, 3) + 64'd1, 12'hFFF, 64'h0000_0000_0000_000C, "R1");
        issue(3'd3, mk(la, 2, 3), 12'd0, '0, "R1");

        // R5: data store keeps the tag
        issue(3'd2, mk(la, 2, 3), 12'd0, 64'hDEAD_BEEF_0123_4567, "R5");
        issue(3'd3, mk(la, 2, 3), 12'd0, '0, "R5");
        issue(3'd1, mk(la, 2, 3), 12'd0, '0, "R5");
        issue(3'd1, mk(la, 2, 2), 12'd0, '0, "R5");

        // R2: misaligned tag ops flag and do nothing
        issue(3'd3, mk(la, 2, 1) + 64'd4, 12'd0, '0, "R2");
        issue(3'd4, mk(la, 2, 1), 12'd3, 64'hF, "R2");
        issue(3'd4, mk(la, 2, 1) + 64'd1, 12'd0, 64'hF, "R2");
        issue(3'd3, mk(la, 2, 1), 12'd0, '0, "R2");
        // R2: data op at unaligned address raises nothing
        issue(3'd1, mk(la, 2, 1) + 64'd5, 12'd0, '0, "R2");

        // R7: stores to another address tag in the same set have no effect
        issue(3'd4, mk(lb, 2, 0), 12'd0, 64'h9, "R7");
        issue(3'd2, mk(lb, 2, 0), 12'd0, 64'h5555, "R7");
        issue(3'd3, mk(lb, 2, 0), 12'd0, '0, "R7");
        issue(3'd3, mk(la, 2, 0), 12'd0, '0, "R7");
        issue(3'd1, mk(la, 2, 0), 12'd0, '0, "R7");

        // R6: fill another set, both sets independent; refill replaces tag
        set_fill(9);
        issue(3'd5, mk(lb, 6, 0), 12'd0, '0, "R6");
        issue(3'd3, mk(lb, 6, 7), 12'd0, '0, "R6");
        issue(3'd3, mk(la, 2, 5), 12'd0, '0, "R6");
        set_fill(12);
        issue(3'd5, mk(lb, 2, 0), 12'd0, '0, "R6");
        issue(3'd3, mk(la, 2, 5), 12'd0, '0, "R7");
        issue(3'd3, mk(lb, 2, 5), 12'd0, '0, "R6");
        issue(3'd1, mk(lb, 2, 6), 12'd0, '0, "R8");
        issue(3'd0, mk(lb, 2, 6), 12'd0, '0, "R8");
        idle(4);

        check(exp_q.size() == 0, "R8", "responses outstanding", 64'(exp_q.size()), 64'd0);
        report();
    end

endmodule